// File: doc/BRIEF.md
# Page Translation Unit with Set-Associative Lookup Cache

This block turns a 14-bit virtual address into a 12-bit physical address for 64-byte pages. A 16-entry lookup cache, organised as 4 sets of 4 ways, holds recently used page table entries. When a lookup finds a matching entry, the physical address is formed without any memory traffic. When it does not, the block issues one read of the page table entry at the table base plus the virtual page number. It then stores a usable entry in the cache and answers the request. Each answer also reports whether the page is absent and whether the access broke the page's permission bits.

Requests and answers are both valid/ready streams. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the answer has been taken, so at most one request is in flight. An answer stays on the response pins, unchanged, for as long as `rsp_ready` is low. The page table read port is a request stream (`mem_req_valid`/`mem_req_ready`) with a single-cycle `mem_rsp_valid` return that carries no back-pressure. `flush` is a plain control pin.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset, `rsp_valid`, `busy` and `mem_req_valid` are 0 and `req_ready` is 1. `req_ready` is high only while no request is in flight.
- R2: The page number is VA[13:6]. The set is page number bits [1:0] and the tag is page number bits [7:2]. A successful answer has `rsp_pa` = {PPN, VA[5:0]}.
- R3: On a cache miss, exactly one page table read is made, at address `ptbase` + page number. The answer appears 3 cycles after acceptance when memory answers at once. `busy` is high while that read is outstanding.
- R4: On a cache hit, no memory read is made, `rsp_hit` is 1, and the answer appears 1 cycle after acceptance.
- R5: Entry format: bits [5:0] are the PPN, bit 6 valid, bit 7 read allowed, bit 8 write allowed, bit 9 supervisor only. A fetched entry with valid = 0 gives `rsp_pfault` = 1, `rsp_prot` = 0 and `rsp_pa` = 0. Such an entry is not cached, so the next access to that page reads memory again.
- R6: A read needs bit 7 and a write needs bit 8. A non-privileged access (`req_priv` = 0) to a page with bit 9 set is refused. A refused access gives `rsp_prot` = 1 and `rsp_pa` = 0. This holds on hits as well as on misses.
- R7: A refill goes into the lowest-numbered invalid way of its set. When every way is valid, it goes into the way named by that set's round-robin pointer. The pointer moves to the way after the one filled.
- R8: `flush` clears every cache entry and every pointer, so each later access misses.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, every response output holds its value and no new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate the whole lookup cache |
| ptbase | input | 12 | Page table base address |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_va | input | 14 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_priv | input | 1 | 1 = privileged access |
| rsp_valid | output | 1 | Answer present |
| rsp_ready | input | 1 | Answer taken |
| rsp_pa | output | 12 | Physical address (0 on any fault) |
| rsp_hit | output | 1 | Answer came from the lookup cache |
| rsp_pfault | output | 1 | Page not present |
| rsp_prot | output | 1 | Permission refused |
| busy | output | 1 | Page table read outstanding |
| mem_req_valid | output | 1 | Page table read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 12 | Address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 10 | Page table entry |

## Verification
Two worked addresses, 0x03D4 and 0x0020, are tried with a non-zero table base. The first tells a miss apart from the hit that follows it, using latency and read count. The second shows that the read address adds the base to the page number. A run of five pages that share one set tells fill-invalid-first apart from round-robin eviction, because exactly the first page must be evicted. Accesses to an absent page, a read-only page and a supervisor page separate the page fault from the two kinds of protection fault, on both the miss path and the hit path. A flush followed by a repeated access, and an answer held under back-pressure, close the set.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } xl_state_e;

  typedef struct packed {
    logic sup;
    logic wr;
    logic rd;
  } xl_perm_t;

  function automatic logic perm_ok(xl_perm_t p, logic is_wr, logic is_priv);
    return (is_wr ? p.wr : p.rd) && (is_priv || !p.sup);
  endfunction

endpackage

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill,
  input  logic [WAYS-1:0]  way_vld,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] rr_q;

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = rr_q;
    for (int w = 0; w < WAYS; w++) begin
      if (!way_vld[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (flush)
      rr_q <= '0;
    else if (fill)
      rr_q <= (victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1;
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output xl_perm_t         lk_perm,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  xl_perm_t         fill_perm
);
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
  xl_perm_t         perm_q [SETS][WAYS];
  logic [WAY_W-1:0] vic    [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    xlate_victim #(.WAYS(WAYS)) u_vic (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .fill    (fill_en && !flush && (fill_idx == IDX_W'(s))),
      .way_vld (vld_q[s]),
      .victim  (vic[s])
    );
  end

  always_comb begin
    lk_hit  = 1'b0;
    lk_ppn  = '0;
    lk_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag) && !lk_hit) begin
        lk_hit  = 1'b1;
        lk_ppn  = ppn_q[lk_idx][w];
        lk_perm = perm_q[lk_idx][w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_en) begin
      vld_q[fill_idx][vic[fill_idx]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[fill_idx][vic[fill_idx]]  <= fill_tag;
      ppn_q[fill_idx][vic[fill_idx]]  <= fill_ppn;
      perm_q[fill_idx][vic[fill_idx]] <= fill_perm;
    end
  end
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int OFS_W  = 6,
  parameter int PPN_W  = 6,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int MEM_AW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [MEM_AW-1:0]      ptbase,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_va,
  input  logic                   req_write,
  input  logic                   req_priv,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PPN_W+OFS_W-1:0] rsp_pa,
  output logic                   rsp_hit,
  output logic                   rsp_pfault,
  output logic                   rsp_prot,
  output logic                   busy,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [MEM_AW-1:0]      mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PPN_W+3:0]       mem_rsp_data
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PA_W  = PPN_W + OFS_W;
  localparam int B_VLD = PPN_W;

  xl_state_e        state_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, priv_q;
  logic [PA_W-1:0]  pa_q;
  logic             hit_q, pf_q, pr_q;

  logic [VPN_W-1:0] vpn;
  logic [OFS_W-1:0] ofs;
  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;
  xl_perm_t         tlb_perm;
  logic             pte_vld;
  logic [PPN_W-1:0] pte_ppn;
  xl_perm_t         pte_perm;
  logic             fill_en;

  assign vpn      = va_q[VA_W-1:OFS_W];
  assign ofs      = va_q[OFS_W-1:0];
  assign pte_ppn  = mem_rsp_data[PPN_W-1:0];
  assign pte_vld  = mem_rsp_data[B_VLD];
  assign pte_perm = mem_rsp_data[PPN_W+3:PPN_W+1];
  assign fill_en  = (state_q == ST_WAIT) && mem_rsp_valid && pte_vld;

  xlate_tlb #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .PPN_W (PPN_W)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_idx    (vpn[IDX_W-1:0]),
    .lk_tag    (vpn[VPN_W-1:IDX_W]),
    .lk_hit    (tlb_hit),
    .lk_ppn    (tlb_ppn),
    .lk_perm   (tlb_perm),
    .fill_en   (fill_en),
    .fill_idx  (vpn[IDX_W-1:0]),
    .fill_tag  (vpn[VPN_W-1:IDX_W]),
    .fill_ppn  (pte_ppn),
    .fill_perm (pte_perm)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign busy          = (state_q == ST_FETCH) || (state_q == ST_WAIT);
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_addr  = ptbase + MEM_AW'(vpn);
  assign rsp_pa        = pa_q;
  assign rsp_hit       = hit_q;
  assign rsp_pfault    = pf_q;
  assign rsp_prot      = pr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      priv_q  <= 1'b0;
      pa_q    <= '0;
      hit_q   <= 1'b0;
      pf_q    <= 1'b0;
      pr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          wr_q    <= req_write;
          priv_q  <= req_priv;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (tlb_hit) begin
          hit_q   <= 1'b1;
          pf_q    <= 1'b0;
          pr_q    <= !perm_ok(tlb_perm, wr_q, priv_q);
          pa_q    <= perm_ok(tlb_perm, wr_q, priv_q) ? {tlb_ppn, ofs} : '0;
          state_q <= ST_RESP;
        end else begin
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          hit_q   <= 1'b0;
          pf_q    <= !pte_vld;
          pr_q    <= pte_vld && !perm_ok(pte_perm, wr_q, priv_q);
          pa_q    <= (pte_vld && perm_ok(pte_perm, wr_q, priv_q)) ? {pte_ppn, ofs} : '0;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int VA_W  = 14,
  parameter int OFS_W = 6,
  parameter int PA_W  = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_hit,
  input logic            rsp_pfault,
  input logic            rsp_prot,
  input logic            busy,
  input logic            mem_req_valid
);
  logic [VA_W-1:0] va_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va_cap <= '0;
    else if (req_valid && req_ready) va_cap <= req_va;
  end

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !rsp_valid));

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_pfault && !rsp_prot) |-> (rsp_pa[OFS_W-1:0] == va_cap[OFS_W-1:0]));

  p_read_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  p_absent_nopa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_pfault) |-> (rsp_pa == '0 && !rsp_prot && !rsp_hit));

  p_refused_nopa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_prot) |-> (rsp_pa == '0));

  p_hold_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)
                                   && $stable(rsp_pfault) && $stable(rsp_prot)));
endmodule

bind addr_xlate_unit xlate_checker #(
  .VA_W  (VA_W),
  .OFS_W (OFS_W),
  .PA_W  (PPN_W + OFS_W)
) u_xlate_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_va        (req_va),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_pa        (rsp_pa),
  .rsp_hit       (rsp_hit),
  .rsp_pfault    (rsp_pfault),
  .rsp_prot      (rsp_prot),
  .busy          (busy),
  .mem_req_valid (mem_req_valid)
);

// File: tb/test_addr_xlate_unit.sv
`timescale 1ns/1ps
module test_addr_xlate_unit;
  localparam logic [11:0] PTB = 12'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [11:0] rsp_pa;
  logic        rsp_hit, rsp_pfault, rsp_prot, busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [11:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [9:0]  mem_rsp_data = '0;

  logic [9:0]  pt [256];
  int          nreads = 0;
  logic [11:0] last_addr = '0;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  addr_xlate_unit i_addr_xlate_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ptbase(PTB),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_hit(rsp_hit), .rsp_pfault(rsp_pfault), .rsp_prot(rsp_prot),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // page table memory: answers one cycle after a read is taken
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= pt[8'(mem_req_addr - PTB)];
    if (mem_req_valid && mem_req_ready) begin
      nreads    <= nreads + 1;
      last_addr <= mem_req_addr;
    end
  end

  // entry = {sup, write, read, valid, ppn[5:0]}
  function automatic logic [9:0] mk_pte(logic s, logic w, logic r, logic v, logic [5:0] p);
    return {s, w, r, v, p};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  logic [11:0] o_pa;
  logic        o_hit, o_pf, o_pr;
  int          o_lat, o_reads;

  task automatic access(logic [13:0] va, logic wr, logic priv);
    int r0;
    @(negedge clk);
    req_va = va; req_write = wr; req_priv = priv; req_valid = 1'b1;
    @(posedge clk);
    r0 = nreads;
    @(negedge clk);
    req_valid = 1'b0;
    o_lat = 0;
    while (!rsp_valid && o_lat < 50) begin
      @(negedge clk);
      o_lat++;
    end
    o_pa = rsp_pa; o_hit = rsp_hit; o_pf = rsp_pfault; o_pr = rsp_prot;
    o_reads = nreads - r0;
    @(posedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "mem_req_valid", mem_req_valid, 0);
    chk("R1", "req_ready", req_ready, 1);
  endtask

  task automatic t_worked_examples;
    access(14'h03D4, 0, 0);
    chk("R3", "miss latency", o_lat, 3);
    chk("R3", "miss reads", o_reads, 1);
    chk("R3", "read address", last_addr, PTB + 12'h0F);
    chk("R2", "pa 0x03D4 miss", o_pa, 12'h354);
    access(14'h03D4, 0, 0);
    chk("R4", "hit flag", o_hit, 1);
    chk("R4", "hit latency", o_lat, 1);
    chk("R4", "hit reads", o_reads, 0);
    chk("R2", "pa 0x03D4 hit", o_pa, 12'h354);
    access(14'h0020, 0, 0);
    chk("R3", "read address 0x0020", last_addr, PTB);
    chk("R2", "pa 0x0020", o_pa, 12'hA20);
  endtask

  task automatic t_page_fault;
    access(14'h0B8F, 0, 0);
    chk("R5", "pfault", o_pf, 1);
    chk("R5", "prot", o_pr, 0);
    chk("R5", "pa", o_pa, 0);
    access(14'h0B8F, 0, 0);
    chk("R5", "absent page read again", o_reads, 1);
    chk("R5", "absent not hit", o_hit, 0);
  endtask

  task automatic t_protect;
    access({8'h11, 6'h05}, 0, 0);
    chk("R6", "ro read ok", o_pr, 0);
    chk("R6", "ro read pa", o_pa, {6'h07, 6'h05});
    access({8'h11, 6'h05}, 1, 0);
    chk("R6", "ro write refused", o_pr, 1);
    chk("R6", "ro write from hit", o_hit, 1);
    chk("R6", "ro write pa", o_pa, 0);
    access({8'h12, 6'h3F}, 0, 0);
    chk("R6", "user on sup page", o_pr, 1);
    chk("R6", "user on sup pa", o_pa, 0);
    access({8'h12, 6'h3F}, 0, 1);
    chk("R6", "priv on sup page", o_pr, 0);
    chk("R6", "priv on sup hit", o_hit, 1);
    chk("R6", "priv on sup pa", o_pa, {6'h09, 6'h3F});
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    access(14'h03D4, 0, 0);
    chk("R8", "miss after flush", o_hit, 0);
    chk("R8", "read after flush", o_reads, 1);
    chk("R8", "pa after flush", o_pa, 12'h354);
  endtask

  task automatic t_replace;
    logic [7:0] pages [5] = '{8'h21, 8'h25, 8'h29, 8'h2D, 8'h31};
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 5; i++) begin
      access({pages[i], 6'h00}, 0, 0);
      chk("R7", "fill miss", o_hit, 0);
    end
    for (int i = 1; i < 5; i++) begin
      access({pages[i], 6'h01}, 0, 0);
      chk("R7", "survivor hit", o_hit, 1);
    end
    access({pages[0], 6'h02}, 0, 0);
    chk("R7", "oldest evicted", o_hit, 0);
    access({pages[2], 6'h02}, 0, 0);
    chk("R7", "next way survives", o_hit, 1);
    access({pages[1], 6'h02}, 0, 0);
    chk("R7", "round robin took way 1", o_hit, 0);
  endtask

  task automatic t_backpressure;
    logic [11:0] pa0;
    int n;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_va = 14'h03D4; req_write = 0; req_priv = 0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    pa0 = rsp_pa;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9", "held valid", rsp_valid, 1);
      chk("R9", "held pa", rsp_pa, pa0);
      chk("R9", "no new request", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9", "released valid", rsp_valid, 0);
    chk("R9", "released ready", req_ready, 1);
  endtask

  initial begin
    for (int v = 0; v < 256; v++) pt[v] = mk_pte(0, 1, 1, 1, 6'(v));
    pt[8'h0F] = mk_pte(0, 1, 1, 1, 6'h0D);
    pt[8'h00] = mk_pte(0, 1, 1, 1, 6'h28);
    pt[8'h2E] = mk_pte(0, 1, 1, 0, 6'h11);
    pt[8'h11] = mk_pte(0, 0, 1, 1, 6'h07);
    pt[8'h12] = mk_pte(1, 1, 1, 1, 6'h09);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_worked_examples();
    t_page_fault();
    t_protect();
    t_flush();
    t_replace();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule